// File: doc/BRIEF.md
# Debug Event Disposition Unit

This block sits beside a processor core and decides, for every debug event the core raises, what must happen to it. Each event arrives as a one-hot class vector with a valid strobe. The unit weighs it against the core's status, which is the authentication enables for each security state, the current security state, the halted flag, the double-lock status and the OS-lock status, and against its own halt-enable control bit. One registered one-hot action comes out on the following cycle: enter debug state, hand over to the software exception model, raise undefined instruction, ignore, or pend.

Four halting-class events can be pended: halting step, external debug request, reset catch and OS-unlock catch. When one of them arrives while halting is prohibited, the unit stores it in a small pending register. That bit is later replayed as a debug-state entry on an idle cycle in which halting is allowed. A debugger can drop pending bits with a clear mask, and a cold (synchronous) reset empties the register.

Top module: `dbgev_disposition`

## Requirements
- R1: Halting is allowed only when `halted` is 0, `dlock` is 0, and the authentication enable for the current state is 1. That enable is `auth_s` when `sec_state` is 1 and `auth_ns` otherwise.
- R2: Event bit 0 is the breakpoint/watchpoint class. It gives enter (action bit 0) only when the halt-enable bit is 1, `oslk` is 0 and halting is allowed. In every other case it gives exception model (action bit 1).
- R3: Event bits 1, 2 and 3 are software step, software breakpoint instruction and vector catch. They always give exception model (action bit 1), whatever the halt-enable bit and the status inputs hold.
- R4: Event bit 4 is the halt instruction. It gives enter when halting is allowed and the halt-enable bit is 1, and gives undefined (action bit 2) otherwise.
- R5: Event bit 5 is exception catch. It gives enter when halting is allowed, and gives ignore (action bit 3) otherwise.
- R6: Event bit 6 is software access. It gives enter when halting is allowed and `oslk` is 0, and gives ignore otherwise.
- R7: Event bits 7 to 10 are halting step, external request, reset catch and OS-unlock catch. Each gives enter when halting is allowed. Otherwise it gives pend (action bit 4) and sets `pend_bits[k-7]` at the same edge as the action.
- R8: A cycle with `ev_vld` low, halting allowed and at least one pending bit set (after any clear in that cycle) yields an enter action with `act_pend` high. It takes the lowest set bit j, reports `act_src` = 7+j, and clears bit j at the same edge.
- R9: Reset clears the pending bits, the halt-enable bit and all action outputs. A `pclr_vld` cycle clears the bits in `pclr_mask`, and a cleared bit is not taken in that cycle. If an event sets the same bit in that cycle, the set wins.
- R10: The action appears one cycle after its strobe with exactly one `act_code` bit set and `act_src` equal to the event bit index. A strobe whose vector is not one-hot produces no action and pends nothing. With no action, `act_vld` and `act_code` are zero.
- R11: The halt-enable bit loads `hde_wd` on a cycle with `hde_we` high, is visible on `hde_bit` the next cycle, and holds otherwise. Decisions use the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| ev_vld | input | 1 | Event strobe |
| ev_vec | input | 11 | One-hot event class |
| auth_ns | input | 1 | Authentication enable, non-secure state |
| auth_s | input | 1 | Authentication enable, secure state |
| sec_state | input | 1 | Core is in secure state |
| halted | input | 1 | Core is already in debug state |
| dlock | input | 1 | Double-lock asserted |
| oslk | input | 1 | OS lock set |
| hde_we | input | 1 | Halt-enable write strobe |
| hde_wd | input | 1 | Halt-enable write value |
| pclr_vld | input | 1 | Debugger clear strobe for pending bits |
| pclr_mask | input | 4 | Pending bits to clear |
| act_vld | output | 1 | Action valid |
| act_code | output | 5 | One-hot action: enter, exception, undefined, ignore, pend |
| act_src | output | 4 | Event bit index the action belongs to |
| act_pend | output | 1 | Action is a replayed pending event |
| pend_bits | output | 4 | Pending register |
| hde_bit | output | 1 | Current halt-enable bit |

## Verification
Every event class is driven under all 64 combinations of halted, double-lock, security state, both authentication enables and OS lock, and each sweep is repeated with the halt-enable bit clear and set. This separates the gating term of each class from the others: OS lock only matters for two classes, and halt-enable only for two. An idle cycle follows each strobe, so that pending events accumulated under prohibition are replayed whenever the next status pattern allows halting. This exposes ordering and bit-clear errors. Directed runs add the lowest-first replay order, a clear that hits the bit about to be taken, a clear that collides with a set, and malformed vectors. A long random mix then covers all of this at once.

// File: rtl/dbgev_pkg.sv
package dbgev_pkg;
  localparam int NUM_EV    = 11;
  localparam int NUM_PEND  = 4;
  localparam int PEND_BASE = 7;
  localparam int NUM_ACT   = 5;
  localparam int EV_IW     = $clog2(NUM_EV);
  localparam int PEND_IW   = $clog2(NUM_PEND);

  localparam int EV_BKWP   = 0;
  localparam int EV_HLTI   = 4;
  localparam int EV_XCATCH = 5;
  localparam int EV_SWACC  = 6;

  localparam int ACT_ENTER = 0;
  localparam int ACT_EXC   = 1;
  localparam int ACT_UNDEF = 2;
  localparam int ACT_IGN   = 3;
  localparam int ACT_PEND  = 4;

  typedef logic [NUM_ACT-1:0] act_t;
  typedef logic [NUM_EV-1:0]  evvec_t;
endpackage

// File: rtl/dbgev_allow.sv
module dbgev_allow (
  input  logic halted_i,
  input  logic dlock_i,
  input  logic sec_i,
  input  logic auth_s_i,
  input  logic auth_ns_i,
  output logic allow_o
);
  logic auth_sel;
  assign auth_sel = sec_i ? auth_s_i : auth_ns_i;
  assign allow_o  = ~halted_i & ~dlock_i & auth_sel;
endmodule

// File: rtl/dbgev_table.sv
module dbgev_table
  import dbgev_pkg::*;
(
  input  evvec_t           ev_i,
  input  logic             allow_i,
  input  logic             hde_i,
  input  logic             oslk_i,
  output logic             single_o,
  output logic [EV_IW-1:0] idx_o,
  output act_t             act_o
);
  assign single_o = (ev_i != '0) && ((ev_i & (ev_i - 1'b1)) == '0);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev_i[i]) idx_o = EV_IW'(i);
    end
  end

  always_comb begin
    act_o = '0;
    if (int'(idx_o) >= PEND_BASE) begin
      if (allow_i) act_o[ACT_ENTER] = 1'b1;
      else         act_o[ACT_PEND]  = 1'b1;
    end else if (int'(idx_o) == EV_BKWP) begin
      if (hde_i && !oslk_i && allow_i) act_o[ACT_ENTER] = 1'b1;
      else                             act_o[ACT_EXC]   = 1'b1;
    end else if (int'(idx_o) == EV_HLTI) begin
      if (allow_i && hde_i) act_o[ACT_ENTER] = 1'b1;
      else                  act_o[ACT_UNDEF] = 1'b1;
    end else if (int'(idx_o) == EV_XCATCH) begin
      if (allow_i) act_o[ACT_ENTER] = 1'b1;
      else         act_o[ACT_IGN]   = 1'b1;
    end else if (int'(idx_o) == EV_SWACC) begin
      if (allow_i && !oslk_i) act_o[ACT_ENTER] = 1'b1;
      else                    act_o[ACT_IGN]   = 1'b1;
    end else begin
      act_o[ACT_EXC] = 1'b1;
    end
  end
endmodule

// File: rtl/dbgev_pend.sv
module dbgev_pend
  import dbgev_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                set_i,
  input  logic [PEND_IW-1:0]  set_bit_i,
  input  logic                clr_i,
  input  logic [NUM_PEND-1:0] clr_mask_i,
  input  logic                fire_en_i,
  output logic [NUM_PEND-1:0] pend_o,
  output logic                fire_o,
  output logic [PEND_IW-1:0]  fire_bit_o
);
  logic [NUM_PEND-1:0] pend_q;
  logic [NUM_PEND-1:0] cand;
  logic [NUM_PEND-1:0] set_oh;
  logic [NUM_PEND-1:0] fire_oh;

  assign cand   = pend_q & ~(clr_i ? clr_mask_i : '0);
  assign fire_o = fire_en_i && (cand != '0);

  always_comb begin
    fire_bit_o = '0;
    for (int i = NUM_PEND - 1; i >= 0; i--) begin
      if (cand[i]) fire_bit_o = PEND_IW'(i);
    end
  end

  for (genvar g = 0; g < NUM_PEND; g++) begin : g_bit
    assign set_oh[g]  = set_i  && (set_bit_i  == PEND_IW'(g));
    assign fire_oh[g] = fire_o && (fire_bit_o == PEND_IW'(g));
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= (cand[g] & ~fire_oh[g]) | set_oh[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dbgev_disposition.sv
module dbgev_disposition
  import dbgev_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_vld,
  input  logic [NUM_EV-1:0]   ev_vec,
  input  logic                auth_ns,
  input  logic                auth_s,
  input  logic                sec_state,
  input  logic                halted,
  input  logic                dlock,
  input  logic                oslk,
  input  logic                hde_we,
  input  logic                hde_wd,
  input  logic                pclr_vld,
  input  logic [NUM_PEND-1:0] pclr_mask,
  output logic                act_vld,
  output logic [NUM_ACT-1:0]  act_code,
  output logic [EV_IW-1:0]    act_src,
  output logic                act_pend,
  output logic [NUM_PEND-1:0] pend_bits,
  output logic                hde_bit
);
  logic               allow;
  logic               single;
  logic [EV_IW-1:0]   idx;
  act_t               act;
  logic               take;
  logic               set_p;
  logic [PEND_IW-1:0] set_bit;
  logic               fire;
  logic [PEND_IW-1:0] fire_bit;
  logic               hde_q;

  dbgev_allow u_allow (
    .halted_i (halted),
    .dlock_i  (dlock),
    .sec_i    (sec_state),
    .auth_s_i (auth_s),
    .auth_ns_i(auth_ns),
    .allow_o  (allow)
  );

  dbgev_table u_table (
    .ev_i    (ev_vec),
    .allow_i (allow),
    .hde_i   (hde_q),
    .oslk_i  (oslk),
    .single_o(single),
    .idx_o   (idx),
    .act_o   (act)
  );

  assign take    = ev_vld & single;
  assign set_p   = take & act[ACT_PEND];
  assign set_bit = PEND_IW'(idx - EV_IW'(PEND_BASE));

  dbgev_pend u_pend (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_p),
    .set_bit_i (set_bit),
    .clr_i     (pclr_vld),
    .clr_mask_i(pclr_mask),
    .fire_en_i (~ev_vld & allow),
    .pend_o    (pend_bits),
    .fire_o    (fire),
    .fire_bit_o(fire_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)         hde_q <= 1'b0;
    else if (hde_we) hde_q <= hde_wd;
  end
  assign hde_bit = hde_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_vld  <= 1'b0;
      act_code <= '0;
      act_src  <= '0;
      act_pend <= 1'b0;
    end else begin
      act_vld  <= take | fire;
      act_pend <= fire;
      if (take) begin
        act_code <= act;
        act_src  <= idx;
      end else if (fire) begin
        act_code <= NUM_ACT'(1) << ACT_ENTER;
        act_src  <= EV_IW'(PEND_BASE) + EV_IW'(fire_bit);
      end else begin
        act_code <= '0;
        act_src  <= '0;
      end
    end
  end
endmodule

// File: rtl/dbgev_disposition_chk.sv
module dbgev_disposition_chk
  import dbgev_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                ev_vld,
  input logic [NUM_EV-1:0]   ev_vec,
  input logic                halted,
  input logic                dlock,
  input logic                hde_we,
  input logic                pclr_vld,
  input logic [NUM_PEND-1:0] pclr_mask,
  input logic                act_vld,
  input logic [NUM_ACT-1:0]  act_code,
  input logic [EV_IW-1:0]    act_src,
  input logic                act_pend,
  input logic [NUM_PEND-1:0] pend_bits,
  input logic                hde_bit
);
  a_r1_no_enter_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && (halted || dlock)) |=> !act_code[ACT_ENTER]);

  a_r3_soft_to_exc: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && (ev_vec == NUM_EV'(2) || ev_vec == NUM_EV'(4) || ev_vec == NUM_EV'(8)))
      |=> (act_code == (NUM_ACT'(1) << ACT_EXC)));

  a_r4_undef_without_hde: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && ev_vec == (NUM_EV'(1) << EV_HLTI) && !hde_bit) |=> act_code[ACT_UNDEF]);

  a_r7_halted_pends: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && halted && ev_vec == (NUM_EV'(1) << PEND_BASE)) |=> (act_code[ACT_PEND] && pend_bits[0]));

  a_r8_taken_bit_clear: assert property (@(posedge clk) disable iff (rst)
    (act_vld && act_pend) |-> (((pend_bits >> (act_src - EV_IW'(PEND_BASE))) & NUM_PEND'(1)) == '0));

  a_r9_clear_bit0: assert property (@(posedge clk) disable iff (rst)
    (pclr_vld && pclr_mask[0] && !(ev_vld && ev_vec[PEND_BASE])) |=> !pend_bits[0]);

  a_r10_single_action: assert property (@(posedge clk) disable iff (rst)
    act_vld |-> ($countones(act_code) == 1));

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !act_vld |-> (act_code == '0));

  a_r11_hde_holds: assert property (@(posedge clk) disable iff (rst)
    !hde_we |=> $stable(hde_bit));
endmodule

bind dbgev_disposition dbgev_disposition_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_vld   (ev_vld),
  .ev_vec   (ev_vec),
  .halted   (halted),
  .dlock    (dlock),
  .hde_we   (hde_we),
  .pclr_vld (pclr_vld),
  .pclr_mask(pclr_mask),
  .act_vld  (act_vld),
  .act_code (act_code),
  .act_src  (act_src),
  .act_pend (act_pend),
  .pend_bits(pend_bits),
  .hde_bit  (hde_bit)
);

// File: tb/dbgev_disposition_bench.sv
module dbgev_disposition_bench;
  logic clk = 1'b0;
  logic rst;
  logic ev_vld;
  logic [10:0] ev_vec;
  logic auth_ns, auth_s, sec_state, halted, dlock, oslk;
  logic hde_we, hde_wd, pclr_vld;
  logic [3:0] pclr_mask;
  logic act_vld;
  logic [4:0] act_code;
  logic [3:0] act_src;
  logic act_pend;
  logic [3:0] pend_bits;
  logic hde_bit;

  always #10 clk = ~clk;

  dbgev_disposition u_dbgev_disposition (
    .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_vec(ev_vec),
    .auth_ns(auth_ns), .auth_s(auth_s), .sec_state(sec_state),
    .halted(halted), .dlock(dlock), .oslk(oslk),
    .hde_we(hde_we), .hde_wd(hde_wd), .pclr_vld(pclr_vld), .pclr_mask(pclr_mask),
    .act_vld(act_vld), .act_code(act_code), .act_src(act_src), .act_pend(act_pend),
    .pend_bits(pend_bits), .hde_bit(hde_bit)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state: expected outputs after each edge
  bit       e_vld;
  bit [4:0] e_code;
  bit [3:0] e_src;
  bit       e_pnd;
  bit [3:0] m_pend;
  bit       m_hde;

  localparam bit [4:0] ENTER = 5'b00001, EXC = 5'b00010, UNDEF = 5'b00100,
                       IGN   = 5'b01000, PND = 5'b10000;

  always @(posedge clk) begin : model
    bit ok_halt;
    bit [3:0] np;
    int k;
    ok_halt = !halted && !dlock && (sec_state ? auth_s : auth_ns);
    if (rst) begin
      e_vld = 0; e_code = 0; e_src = 0; e_pnd = 0; m_pend = 0; m_hde = 0;
    end else begin
      e_vld = 0; e_code = 0; e_src = 0; e_pnd = 0;
      np = m_pend & ~(pclr_vld ? pclr_mask : 4'b0);
      if (ev_vld) begin
        if ($countones(ev_vec) == 1) begin
          k = 0;
          for (int i = 0; i < 11; i++) if (ev_vec[i]) k = i;
          e_vld = 1;
          e_src = 4'(k);
          if (k >= 7) begin
            if (ok_halt) e_code = ENTER;
            else begin e_code = PND; np[k-7] = 1'b1; end
          end else if (k == 0) e_code = (m_hde && !oslk && ok_halt) ? ENTER : EXC;
          else if (k <= 3)     e_code = EXC;
          else if (k == 4)     e_code = (ok_halt && m_hde) ? ENTER : UNDEF;
          else if (k == 5)     e_code = ok_halt ? ENTER : IGN;
          else                 e_code = (ok_halt && !oslk) ? ENTER : IGN;
        end
      end else if (ok_halt && np != 0) begin
        k = 3;
        for (int j = 3; j >= 0; j--) if (np[j]) k = j;
        e_vld = 1; e_code = ENTER; e_pnd = 1; e_src = 4'(7 + k);
        np[k] = 1'b0;
      end
      m_pend = np;
      if (hde_we) m_hde = hde_wd;
    end
  end

  task automatic tick(input string req);
    @(negedge clk);
    checks++;
    if (act_vld !== e_vld || act_code !== e_code || act_src !== e_src ||
        act_pend !== e_pnd || pend_bits !== m_pend || hde_bit !== m_hde) begin
      fails++;
      $display("FAIL %s: got vld=%0b code=%b src=%0d pnd=%0b pend=%b hde=%0b, expected vld=%0b code=%b src=%0d pnd=%0b pend=%b hde=%0b",
               req, act_vld, act_code, act_src, act_pend, pend_bits, hde_bit,
               e_vld, e_code, e_src, e_pnd, m_pend, m_hde);
    end
  endtask

  function automatic string tag_of(input int k);
    if (k == 0) return "R2";
    if (k <= 3) return "R3";
    if (k == 4) return "R4";
    if (k == 5) return "R5";
    if (k == 6) return "R6";
    return "R7";
  endfunction

  task automatic status(input bit [5:0] s);
    {halted, dlock, sec_state, auth_s, auth_ns, oslk} = s;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin : main
    rst = 1; ev_vld = 0; ev_vec = 0; hde_we = 0; hde_wd = 0; pclr_vld = 0; pclr_mask = 0;
    status(6'b000110);
    repeat (3) tick("R9");
    rst = 0;
    tick("R9");

    // R11: halt-enable write and hold
    hde_we = 1; hde_wd = 1; tick("R11");
    hde_we = 0; tick("R11");
    hde_we = 1; hde_wd = 0; tick("R11");
    hde_we = 0; tick("R11");

    // R1: halting-allowed predicate through the exception-catch class
    for (int s = 0; s < 32; s++) begin
      status(6'(s << 1));
      ev_vld = 1; ev_vec = 11'(1 << 5); tick("R1");
      ev_vld = 0; tick("R1");
    end

    // Full sweep of every class against every status pattern, both halt-enable values
    for (int h = 0; h < 2; h++) begin
      hde_we = 1; hde_wd = h[0]; tick("R11");
      hde_we = 0;
      for (int k = 0; k < 11; k++) begin
        for (int s = 0; s < 64; s++) begin
          status(6'(s));
          ev_vld = 1; ev_vec = 11'(1 << k); tick(tag_of(k));
          ev_vld = 0; tick("R8");
        end
      end
    end

    // R8: lowest-first replay
    pclr_vld = 1; pclr_mask = 4'hF; status(6'b100110); tick("R9");
    pclr_vld = 0; pclr_mask = 0;
    ev_vld = 1; ev_vec = 11'(1 << 10); tick("R7");
    ev_vec = 11'(1 << 8); tick("R7");
    ev_vec = 11'(1 << 7); tick("R7");
    ev_vld = 0; tick("R8");
    status(6'b000110);
    repeat (4) tick("R8");

    // R9: debugger clear removes a bit before it is taken; set wins over clear
    status(6'b100110);
    ev_vld = 1; ev_vec = 11'(1 << 9); tick("R7");
    ev_vec = 11'(1 << 8); tick("R7");
    ev_vld = 0; pclr_vld = 1; pclr_mask = 4'b0100; status(6'b000110); tick("R9");
    pclr_vld = 0; pclr_mask = 0;
    repeat (2) tick("R8");
    status(6'b100110);
    ev_vld = 1; ev_vec = 11'(1 << 7); pclr_vld = 1; pclr_mask = 4'b0001; tick("R9");
    ev_vld = 0; pclr_vld = 0; pclr_mask = 0; tick("R9");

    // R10: malformed vectors, also while a pending bit could be taken
    status(6'b000110);
    ev_vld = 1; ev_vec = 11'b0; tick("R10");
    ev_vec = 11'b011; tick("R10");
    ev_vec = 11'(3 << 7); tick("R10");
    ev_vld = 0; ev_vec = 11'(1 << 4); tick("R10");
    tick("R8");

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      status(6'($urandom));
      ev_vld = $urandom_range(0, 3) != 0;
      ev_vec = ($urandom_range(0, 7) == 0) ? 11'($urandom) : 11'(1 << $urandom_range(0, 10));
      hde_we = $urandom_range(0, 15) == 0; hde_wd = 1'($urandom);
      pclr_vld = $urandom_range(0, 15) == 0; pclr_mask = 4'($urandom);
      tick("R10");
    end
    ev_vld = 0; hde_we = 0; pclr_vld = 0;

    // R9: reset empties everything again
    status(6'b100110);
    ev_vld = 1; ev_vec = 11'(1 << 10); tick("R7");
    ev_vld = 0; rst = 1; tick("R9");
    rst = 0; tick("R9");
    finish_run();
  end
endmodule